// File: doc/BRIEF.md
# Global Chop Demodulation Controller

This block sits beside a converter front end that has a reversing switch ahead of its modulator. It drives the switch polarity and flips it after every finished conversion. Each conversion therefore measures either the true differential input less a fixed internal offset, or the negated input less the same offset. The block receives each signed conversion result together with a one-cycle valid strobe. It subtracts the inverted-phase result from the normal-phase result of each adjacent pair and halves the difference. The offset cancels, and what is left is the input value alone.

After a start, the first conversion is only stored. From the second conversion on, every conversion yields one result, always paired with the conversion just before it. A start pulse, or any change of the chop-enable input, restarts the sequence so that results from different runs are never mixed. With chop disabled, the switch stays in the normal position and results pass straight through.

Top module: `chop_demod`

## Requirements
- R1: While chop is enabled, `pol_o` toggles once for every accepted sample. `pol_o`=0 means normal phase and `pol_o`=1 means inverted phase.
- R2: The first sample accepted after a restart produces no result.
- R3: The second sample after a restart produces `res_o` = floor((normal-phase sample − inverted-phase sample) / 2).
- R4: Every later sample produces a result from itself and the sample just before it, with the normal-phase value always as the minuend.
- R5: While `start_i` is high, `pol_o` returns to 0 and any stored sample is dropped. A sample arriving in the same cycle as the start is also dropped.
- R6: The subtraction never overflows. Full-scale inputs of opposite sign give exact floor results within W bits.
- R7: While chop is disabled, `pol_o` stays 0 and each sample appears unchanged on `res_o` one clock later.
- R8: A change of `chop_en_i` acts as a restart. The sample in that cycle is dropped, and the pairing starts over in normal phase.
- R9: `res_valid_o` is a single-cycle pulse, registered one clock after the `smp_valid_i` that caused it. After reset, `pol_o` and `res_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart the chop sequence |
| chop_en_i | input | 1 | Enable chop demodulation |
| smp_valid_i | input | 1 | Conversion result strobe |
| smp_i | input | W | Signed conversion result |
| pol_o | output | 1 | Switch polarity, 0 normal / 1 inverted |
| res_valid_o | output | 1 | Result strobe |
| res_o | output | W | Signed demodulated result |

## Verification
The bench sweeps every pair of 4-bit samples, plus a third sample after each pair. This catches a design that reverses the minuend on alternate outputs, which would flip the sign of every other result. It also catches a design that rounds toward zero instead of flooring, which would be off by one on odd negative differences. The sweep includes the extreme pair of the most negative and most positive values. A design that subtracted at W bits would wrap the sign there. Further cases put a sample in the same cycle as a start and toggle the chop enable in the middle of a sequence. A design that kept the stale sample would output a result where none is due.

// File: rtl/chop_demod.sv
module chop_demod #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                chop_en_i,
  input  logic                smp_valid_i,
  input  logic signed [W-1:0] smp_i,
  output logic                pol_o,
  output logic                res_valid_o,
  output logic signed [W-1:0] res_o
);

  logic                en_q;
  logic                have_prev;
  logic signed [W-1:0] prev_q;

  wire restart = start_i | (chop_en_i != en_q);
  wire signed [W:0] cur_x  = {smp_i[W-1], smp_i};
  wire signed [W:0] prev_x = {prev_q[W-1], prev_q};
  wire signed [W:0] diff   = pol_o ? (prev_x - cur_x) : (cur_x - prev_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      have_prev   <= 1'b0;
      prev_q      <= '0;
      pol_o       <= 1'b0;
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      en_q        <= chop_en_i;
      res_valid_o <= 1'b0;
      if (restart) begin
        pol_o     <= 1'b0;
        have_prev <= 1'b0;
      end else if (smp_valid_i) begin
        if (!chop_en_i) begin
          res_o       <= smp_i;
          res_valid_o <= 1'b1;
        end else begin
          prev_q    <= smp_i;
          have_prev <= 1'b1;
          pol_o     <= ~pol_o;
          if (have_prev) begin
            res_o       <= W'(diff >>> 1);
            res_valid_o <= 1'b1;
          end
        end
      end
    end
  end

  // R1
  a_r1_pol_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && smp_valid_i && chop_en_i) |=> (pol_o != $past(pol_o)));
  // R2
  a_r2_first_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !have_prev && smp_valid_i && chop_en_i) |=> !res_valid_o);
  // R5, R8
  a_r5_restart_normal: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!pol_o && !res_valid_o));
  // R7
  a_r7_off_normal: assert property (@(posedge clk) disable iff (!rst_n)
    !chop_en_i |=> !pol_o);
  // R9
  a_r9_valid_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(smp_valid_i));

endmodule

// File: tb/chop_demod_tb.sv
`timescale 1ns/1ps
module chop_demod_tb;
  localparam int W = 4;
  logic clk = 0, rst_n = 0, start_i = 0, chop_en_i = 0, smp_valid_i = 0;
  logic signed [W-1:0] smp_i = '0;
  logic pol_o, res_valid_o;
  logic signed [W-1:0] res_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chop_demod #(.W(W)) u_dut (.clk(clk), .rst_n(rst_n), .start_i(start_i),
    .chop_en_i(chop_en_i), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
    .pol_o(pol_o), .res_valid_o(res_valid_o), .res_o(res_o));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic send(input int v);
    @(negedge clk); smp_valid_i = 1; smp_i = W'(v);
    @(negedge clk); smp_valid_i = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset pol", pol_o, 0);
    chk("R9 reset valid", res_valid_o, 0);
    rst_n = 1;
    // R7 pass-through sweep
    for (int v = -8; v < 8; v++) begin
      send(v);
      chk("R7 pass valid", res_valid_o, 1);
      chk("R7 pass data", int'(res_o), v);
      chk("R7 pol", pol_o, 0);
      @(negedge clk);
      chk("R9 single pulse", res_valid_o, 0);
    end
    chop_en_i = 1;
    @(negedge clk);
    // R1..R4, R6 exhaustive pair sweep
    for (int a = -8; a < 8; a++) begin
      for (int b = -8; b < 8; b++) begin
        int c, d;
        do_start();
        chk("R5 pol after start", pol_o, 0);
        send(a);
        chk("R2 first held", res_valid_o, 0);
        chk("R1 pol inverted", pol_o, 1);
        send(b);
        d = a - b;
        chk("R3 valid", res_valid_o, 1);
        chk("R3 R6 data", int'(res_o), d >>> 1);
        chk("R1 pol normal", pol_o, 0);
        c = (a + b + 16) % 16 - 8;
        send(c);
        d = c - b;
        chk("R4 valid", res_valid_o, 1);
        chk("R4 data", int'(res_o), d >>> 1);
        send(a);
        d = c - a;
        chk("R4 normal minuend", int'(res_o), d >>> 1);
      end
    end
    // R5 sample in the start cycle is dropped
    do_start();
    send(3);
    @(negedge clk); start_i = 1; smp_valid_i = 1; smp_i = 4'sd5;
    @(negedge clk); start_i = 0; smp_valid_i = 0;
    chk("R5 no out on start", res_valid_o, 0);
    chk("R5 pol normal", pol_o, 0);
    send(-2);
    chk("R5 stale dropped", res_valid_o, 0);
    send(-6);
    chk("R5 fresh pair", int'(res_o), (-2 - -6) >>> 1);
    // R8 enable change restarts
    send(1);
    chk("R8 pol before", pol_o, 1);
    @(negedge clk); chop_en_i = 0; smp_valid_i = 1; smp_i = 4'sd7;
    @(negedge clk); smp_valid_i = 0;
    chk("R8 dropped on change", res_valid_o, 0);
    chk("R8 pol normal", pol_o, 0);
    @(negedge clk); chop_en_i = 1;
    @(negedge clk);
    send(2);
    chk("R8 first after change held", res_valid_o, 0);
    send(-8);
    chk("R8 new pair", int'(res_o), 5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule